// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block holds the interrupt bookkeeping and the register pointer of a two-channel serial controller. It has no shift registers and no baud logic. A processor reaches it over a byte-wide register bus. One address bit picks the channel and the other picks either the control path or the data path. The host of the block offers received characters and break events on per-channel inputs. The block decides whether each receive or transmit condition is only pending or is also in service. It returns one combined active-high interrupt line.

Each channel keeps a pending flag and an in-service flag for receive and for transmit. Receive service takes precedence: a transmit request that arrives while a receive is in service waits as pending. Later commands and data reads promote it. A shared vector byte reports the highest condition in service, and a status-high option selects between two code sets. A shared interrupt-pending byte shows which conditions are in service. Commands written through the control path step the register pointer, clear the transmit interrupt, release the highest in-service condition and reset either channel or both.

Top module: `sio_irq_arbiter`

## Requirements
- R1: The address map is: `bus_addr[1]`=1 selects channel A and 0 selects channel B; `bus_addr[0]`=1 selects data and 0 selects control. A control write while the channel pointer is 0 loads the pointer from data bits 2:0 and takes a command from bits 5:3. Command 001 adds 8 to the loaded pointer. A control read with pointer 8 returns the last received character.
- R2: A control write while the pointer is non-zero updates the addressed write register and returns the pointer to 0. Every control read returns the pointer to 0, so the next control read returns status (register 0).
- R3: `irq` is high when either channel meets any of these: write register 1 bit 1 set with transmit pending; write register 1 bits 4:3 equal to 01 or 10 with receive pending; write register 15 bit 7 set with status bit 7 (break) set. Write register 15 bit 7 is set by reset.
- R4: An accepted character makes receive pending and in service. A transmit request goes in service only when no receive is in service on that channel; otherwise it stays pending.
- R5: Command 111 (reset highest in-service) acts as follows. If receive is in service, it clears that flag and puts a pending transmit in service. Otherwise it clears transmit in-service. Command 101 clears transmit pending and in-service, and puts a still-pending receive back in service.
- R6: A data read returns the received character and clears status bit 0 and both receive flags. A transmit that is still pending then goes in service.
- R7: Control register 2 of either channel returns a vector that follows fixed priority, A receive > A transmit > B receive > B transmit > none. With status-high set the codes are 0x30, 0x10, 0x20, 0x00 and 0x60. With status-high clear they are 0x0C, 0x08, 0x04, 0x00 and 0x06.
- R8: Control register 3 of channel A returns the pending byte of in-service flags: bit 5 A receive, bit 4 A transmit, bit 2 B receive, bit 1 B transmit. On channel B, register 3 reads 0.
- R9: A data write sets status bit 2 (transmit empty) and special-status bit 0 (all sent), then raises a transmit request.
- R10: A character is accepted only while write register 3 bit 0 is set and status bit 0 is clear. Otherwise it is dropped, and the first waiting character is kept.
- R11: A write to register 9 with bits 7:6 of 01 resets channel B, 10 resets channel A, and 11 resets both. A reset clears all flags, the pointer and the interrupt enables, and restores status 0x44 and special status 0x07. Bit 4 (status-high) is stored only when bits 7:6 are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Bit 1 channel (1 = A), bit 0 path (1 = data) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| rx_valid | input | 2 | Per-channel character offer (bit 1 = A) |
| rx_char | input | 16 | Offered characters, channel A in bits 15:8 |
| rx_break | input | 2 | Per-channel break event (bit 1 = A) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: break interrupt enabled out of reset and status-high cleared. The enabled break lets a single break pulse raise `irq` straight after a channel reset. The cleared status-high bit means the bench must set it through register 9 before it can see the high-code vectors. With these defaults, the directed sequences can reach every vector code and the rebuild of the pending byte after each command. They also reach the reset-code write that must leave status-high untouched.

// File: rtl/sio_irq_pkg.sv
// Shared types and constants for the serial interrupt arbiter.
// Assumes byte-wide registers and exactly two channels (index 1 = A).
package sio_irq_pkg;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 4;
    localparam int NUM_CH  = 2;
    localparam int CH_A    = 1;
    localparam int CH_B    = 0;

    localparam logic [2:0] CMD_HIGH    = 3'b001;
    localparam logic [2:0] CMD_CLR_TX  = 3'b101;
    localparam logic [2:0] CMD_RST_IUS = 3'b111;

    localparam logic [PTR_W-1:0] REG_IEN   = 4'd1;
    localparam logic [PTR_W-1:0] REG_VEC   = 4'd2;
    localparam logic [PTR_W-1:0] REG_RXEN  = 4'd3;
    localparam logic [PTR_W-1:0] REG_RXBUF = 4'd8;
    localparam logic [PTR_W-1:0] REG_RESET = 4'd9;
    localparam logic [PTR_W-1:0] REG_XIEN  = 4'd15;

    // Per-channel pending / in-service flags
    typedef struct packed {
        logic rx_pend;
        logic rx_ius;
        logic tx_pend;
        logic tx_ius;
    } svc_t;
endpackage

// File: rtl/sio_chan_ctl.sv
// One channel: pointer sequencing, command decode, receive acceptance and
// the pending/in-service flags. Assumes at most one bus access per cycle;
// bus effects are applied before a same-cycle character offer.
module sio_chan_ctl
    import sio_irq_pkg::*;
#(
    parameter bit RST_BRK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_break,
    output logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] spec,
    output logic [BYTE_W-1:0] rx_buf,
    output svc_t              svc,
    output logic              req
);
    logic [PTR_W-1:0]  ptr_q, ptr_n;
    logic              tx_ien_q, tx_ien_n;
    logic [1:0]        rx_mode_q, rx_mode_n;
    logic              rx_en_q, rx_en_n;
    logic              brk_en_q, brk_en_n;
    logic              rxav_q, rxav_n, brk_q, brk_n;
    logic              txe_q, txe_n, alls_q, alls_n;
    logic [BYTE_W-1:0] rxbuf_q, rxbuf_n;
    svc_t              svc_q, svc_n;
    logic [2:0]        cmd;
    logic              unused_bit6;

    assign cmd         = wdata[5:3];
    assign unused_bit6 = wdata[6];

    // Next-state: bus access first, then character offer, then break
    always_comb begin
        ptr_n = ptr_q;   tx_ien_n = tx_ien_q; rx_mode_n = rx_mode_q;
        rx_en_n = rx_en_q; brk_en_n = brk_en_q; rxav_n = rxav_q;
        brk_n = brk_q;   txe_n = txe_q;       alls_n = alls_q;
        rxbuf_n = rxbuf_q; svc_n = svc_q;
        if (ctrl_wr) begin
            if (ptr_q == '0) begin
                ptr_n = {cmd == CMD_HIGH, wdata[2:0]};
                if (cmd == CMD_CLR_TX) begin
                    svc_n.tx_pend = 1'b0;
                    svc_n.tx_ius  = 1'b0;
                    if (svc_n.rx_pend) svc_n.rx_ius = 1'b1;
                end else if (cmd == CMD_RST_IUS) begin
                    if (svc_n.rx_ius) begin
                        svc_n.rx_ius = 1'b0;
                        if (svc_n.tx_pend) svc_n.tx_ius = 1'b1;
                    end else begin
                        svc_n.tx_ius = 1'b0;
                    end
                end
            end else begin
                if (ptr_q == REG_IEN) begin
                    tx_ien_n  = wdata[1];
                    rx_mode_n = wdata[4:3];
                end
                if (ptr_q == REG_RXEN) rx_en_n  = wdata[0];
                if (ptr_q == REG_XIEN) brk_en_n = wdata[7];
                ptr_n = '0;
            end
        end
        if (ctrl_rd) ptr_n = '0;
        if (data_wr) begin
            txe_n = 1'b1;
            alls_n = 1'b1;
            svc_n.tx_pend = 1'b1;
            if (!svc_n.rx_ius) svc_n.tx_ius = 1'b1;
        end
        if (data_rd) begin
            rxav_n = 1'b0;
            svc_n.rx_pend = 1'b0;
            svc_n.rx_ius  = 1'b0;
            if (svc_n.tx_pend) svc_n.tx_ius = 1'b1;
        end
        if (rx_valid && rx_en_q && !rxav_n) begin
            rxav_n = 1'b1;
            rxbuf_n = rx_char;
            svc_n.rx_pend = 1'b1;
            svc_n.rx_ius  = 1'b1;
        end
        if (rx_break) brk_n = 1'b1;
    end

    // State registers with power-on and command reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ptr_q <= '0;  tx_ien_q <= 1'b0; rx_mode_q <= 2'b00;
            rx_en_q <= 1'b0; brk_en_q <= RST_BRK_EN;
            rxav_q <= 1'b0; brk_q <= 1'b0; txe_q <= 1'b1; alls_q <= 1'b1;
            rxbuf_q <= '0; svc_q <= '0;
        end else begin
            ptr_q <= ptr_n;  tx_ien_q <= tx_ien_n; rx_mode_q <= rx_mode_n;
            rx_en_q <= rx_en_n; brk_en_q <= brk_en_n;
            rxav_q <= rxav_n; brk_q <= brk_n; txe_q <= txe_n; alls_q <= alls_n;
            rxbuf_q <= rxbuf_n; svc_q <= svc_n;
        end
    end

    // Request and readable views of the channel state
    always_comb begin
        req = (tx_ien_q & svc_q.tx_pend)
            | (((rx_mode_q == 2'b01) || (rx_mode_q == 2'b10)) & svc_q.rx_pend)
            | (brk_en_q & brk_q);
        status = {brk_q, 1'b1, 3'b000, txe_q, 1'b0, rxav_q};
        spec   = {5'b00000, 2'b11, alls_q};
    end

    assign ptr    = ptr_q;
    assign rx_buf = rxbuf_q;
    assign svc    = svc_q;
endmodule

// File: rtl/sio_vec_enc.sv
// Builds the shared vector and in-service pending bytes from both channels'
// flags. Purely combinational; priority A rx > A tx > B rx > B tx.
module sio_vec_enc
    import sio_irq_pkg::*;
(
    input  svc_t              svc_a,
    input  svc_t              svc_b,
    input  logic              stat_hi,
    output logic [BYTE_W-1:0] vec,
    output logic [BYTE_W-1:0] ip
);
    // Priority encode the highest in-service condition
    always_comb begin
        if (svc_a.rx_ius)      vec = stat_hi ? 8'h30 : 8'h0C;
        else if (svc_a.tx_ius) vec = stat_hi ? 8'h10 : 8'h08;
        else if (svc_b.rx_ius) vec = stat_hi ? 8'h20 : 8'h04;
        else if (svc_b.tx_ius) vec = 8'h00;
        else                   vec = stat_hi ? 8'h60 : 8'h06;
    end

    // Place in-service flags at their fixed bit positions
    always_comb begin
        ip = '0;
        ip[5] = svc_a.rx_ius;
        ip[4] = svc_a.tx_ius;
        ip[2] = svc_b.rx_ius;
        ip[1] = svc_b.tx_ius;
    end
endmodule

// File: rtl/sio_irq_arbiter.sv
// Top: address decode, per-channel controllers, reset command decode,
// shared status-high bit and read-data multiplexing. Assumes one bus
// strobe (bus_wr or bus_rd) per cycle.
module sio_irq_arbiter
    import sio_irq_pkg::*;
#(
    parameter bit RST_BRK_EN  = 1'b1,
    parameter bit STAT_HI_RST = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]        rx_valid,
    input  logic [NUM_CH*BYTE_W-1:0] rx_char,
    input  logic [NUM_CH-1:0]        rx_break,
    output logic                     irq
);
    logic [PTR_W-1:0]  ptr_w    [NUM_CH];
    logic [BYTE_W-1:0] status_w [NUM_CH];
    logic [BYTE_W-1:0] spec_w   [NUM_CH];
    logic [BYTE_W-1:0] rxbuf_w  [NUM_CH];
    svc_t              svc_w    [NUM_CH];
    logic [NUM_CH-1:0] req_w;
    logic [NUM_CH-1:0] soft_rst;
    logic              sel;
    logic              reset_hit;
    logic              stat_hi_q;
    logic [BYTE_W-1:0] vec, ip;
    svc_t              svc_a, svc_b;
    logic [PTR_W-1:0]  ptr_a, ptr_b;

    assign sel = bus_addr[1];

    // Register 9 write on the addressed channel: reset field decode
    assign reset_hit   = bus_wr && !bus_addr[0] && (ptr_w[sel] == REG_RESET);
    assign soft_rst[CH_B] = reset_hit && bus_wdata[6];
    assign soft_rst[CH_A] = reset_hit && bus_wdata[7];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit;
        assign hit = (bus_addr[1] == 1'(c));
        sio_chan_ctl #(.RST_BRK_EN(RST_BRK_EN)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst[c]),
            .ctrl_wr  (hit && bus_wr && !bus_addr[0]),
            .ctrl_rd  (hit && bus_rd && !bus_addr[0]),
            .data_wr  (hit && bus_wr &&  bus_addr[0]),
            .data_rd  (hit && bus_rd &&  bus_addr[0]),
            .wdata    (bus_wdata),
            .rx_valid (rx_valid[c]),
            .rx_char  (rx_char[c*BYTE_W +: BYTE_W]),
            .rx_break (rx_break[c]),
            .ptr      (ptr_w[c]),
            .status   (status_w[c]),
            .spec     (spec_w[c]),
            .rx_buf   (rxbuf_w[c]),
            .svc      (svc_w[c]),
            .req      (req_w[c])
        );
    end

    // Status-high option: stored only by a register 9 write with no reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_hi_q <= STAT_HI_RST;
        else if (reset_hit && bus_wdata[7:6] == 2'b00)
            stat_hi_q <= bus_wdata[4];
    end

    assign svc_a = svc_w[CH_A];
    assign svc_b = svc_w[CH_B];
    assign ptr_a = ptr_w[CH_A];
    assign ptr_b = ptr_w[CH_B];

    sio_vec_enc u_vec (
        .svc_a   (svc_a),
        .svc_b   (svc_b),
        .stat_hi (stat_hi_q),
        .vec     (vec),
        .ip      (ip)
    );

    // Read data for the addressed channel and path
    always_comb begin
        if (bus_addr[0]) begin
            bus_rdata = rxbuf_w[sel];
        end else begin
            case (ptr_w[sel])
                4'd0:      bus_rdata = status_w[sel];
                4'd1:      bus_rdata = spec_w[sel];
                REG_VEC:   bus_rdata = vec;
                4'd3:      bus_rdata = sel ? ip : '0;
                REG_RXBUF: bus_rdata = rxbuf_w[sel];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = |req_w;
endmodule

// File: rtl/sio_irq_chk.sv
// Assertion checker for sio_irq_arbiter, attached with bind.
module sio_irq_chk
    import sio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input svc_t              svc_a,
    input svc_t              svc_b,
    input logic [PTR_W-1:0]  ptr_a,
    input logic [PTR_W-1:0]  ptr_b,
    input logic [BYTE_W-1:0] vec
);
    AST_RX_IUS_A_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        svc_a.rx_ius |-> svc_a.rx_pend); // R4
    AST_RX_IUS_B_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        svc_b.rx_ius |-> svc_b.rx_pend); // R4
    AST_TX_IUS_A_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        svc_a.tx_ius |-> svc_a.tx_pend); // R4
    AST_TX_WAITS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b11 && svc_a.rx_ius && !svc_a.tx_ius)
        |=> !svc_a.tx_ius); // R4
    AST_PTR_ZERO_RD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'b10) |=> (ptr_a == '0)); // R2
    AST_PTR_ZERO_RD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'b00) |=> (ptr_b == '0)); // R2
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_a.rx_ius && !svc_a.tx_ius && !svc_b.rx_ius && !svc_b.tx_ius)
        |-> (vec == 8'h06 || vec == 8'h60)); // R7
endmodule

bind sio_irq_arbiter sio_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .svc_a    (svc_a),
    .svc_b    (svc_b),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b),
    .vec      (vec)
);

// File: tb/sio_irq_arbiter_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module sio_irq_arbiter_tb;
    localparam logic CHA = 1'b1;
    localparam logic CHB = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_valid = '0, rx_break = '0;
    logic [15:0] rx_char = '0;
    logic        irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sio_irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_break(rx_break), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input logic [1:0] a, input logic wr, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic ctrl_wr(input logic ch, input logic [7:0] d);
        logic [7:0] q;
        bus_op({ch, 1'b0}, 1'b1, d, q);
    endtask

    task automatic data_wr(input logic ch, input logic [7:0] d);
        logic [7:0] q;
        bus_op({ch, 1'b1}, 1'b1, d, q);
    endtask

    task automatic data_rd(input logic ch, output logic [7:0] q);
        bus_op({ch, 1'b1}, 1'b0, 8'h00, q);
    endtask

    task automatic ctrl_rd(input logic ch, output logic [7:0] q);
        bus_op({ch, 1'b0}, 1'b0, 8'h00, q);
    endtask

    task automatic point(input logic ch, input int r);
        if (r >= 8) ctrl_wr(ch, 8'h08 | 8'(r & 7));
        else if (r != 0) ctrl_wr(ch, 8'(r));
    endtask

    task automatic wreg(input logic ch, input int r, input logic [7:0] v);
        point(ch, r);
        ctrl_wr(ch, v);
    endtask

    task automatic rreg(input logic ch, input int r, output logic [7:0] q);
        point(ch, r);
        ctrl_rd(ch, q);
    endtask

    task automatic rx_pulse(input logic ch, input logic [7:0] d);
        @(negedge clk);
        rx_valid[ch] = 1'b1; rx_char[ch*8 +: 8] = d;
        @(posedge clk); #1;
        rx_valid = '0;
    endtask

    task automatic brk_pulse(input logic ch);
        @(negedge clk);
        rx_break[ch] = 1'b1;
        @(posedge clk); #1;
        rx_break = '0;
    endtask

    task automatic t_reset_state();
        logic [7:0] q;
        check("R3 irq after reset", {7'b0, irq}, 8'h00);
        rreg(CHA, 0, q); check("R11 status A", q, 8'h44);
        rreg(CHA, 1, q); check("R11 special A", q, 8'h07);
        rreg(CHB, 2, q); check("R7 idle vector", q, 8'h06);
        rreg(CHA, 3, q); check("R8 pending idle", q, 8'h00);
    endtask

    task automatic t_rx_basic();
        logic [7:0] q;
        wreg(CHA, 3, 8'h01);
        wreg(CHA, 1, 8'h10);
        rx_pulse(CHA, 8'h5A);
        check("R3 irq on A rx", {7'b0, irq}, 8'h01);
        rreg(CHA, 2, q); check("R7 A rx vector low", q, 8'h0C);
        rreg(CHA, 3, q); check("R4 A rx in service", q, 8'h20);
        rreg(CHA, 0, q); check("R10 rx available", q, 8'h45);
        data_rd(CHA, q); check("R6 data read", q, 8'h5A);
        check("R6 irq clear", {7'b0, irq}, 8'h00);
        rreg(CHA, 3, q); check("R6 pending clear", q, 8'h00);
        rreg(CHA, 0, q); check("R6 rx avail clear", q, 8'h44);
    endtask

    task automatic t_stat_hi();
        logic [7:0] q;
        wreg(CHA, 9, 8'h10);
        rx_pulse(CHA, 8'h21);
        rreg(CHB, 2, q); check("R7 A rx vector high", q, 8'h30);
        data_rd(CHA, q);
        rreg(CHB, 2, q); check("R7 idle vector high", q, 8'h60);
        wreg(CHB, 3, 8'h01);
        wreg(CHB, 1, 8'h08);
        rx_pulse(CHB, 8'h77);
        rreg(CHA, 2, q); check("R7 B rx vector high", q, 8'h20);
        rreg(CHA, 3, q); check("R8 B rx bit", q, 8'h04);
        check("R12 irq from B", {7'b0, irq}, 8'h01);
        data_rd(CHB, q); check("R12 B data read", q, 8'h77);
        wreg(CHA, 9, 8'h00);
    endtask

    task automatic t_tx_blocked();
        logic [7:0] q;
        wreg(CHA, 1, 8'h12);
        rx_pulse(CHA, 8'h33);
        data_wr(CHA, 8'hA5);
        rreg(CHA, 3, q); check("R4 tx stays pending", q, 8'h20);
        rreg(CHA, 2, q); check("R4 vector still rx", q, 8'h0C);
        ctrl_wr(CHA, 8'h38);
        rreg(CHA, 3, q); check("R5 reset ius promotes tx", q, 8'h10);
        rreg(CHA, 2, q); check("R7 A tx vector low", q, 8'h08);
        ctrl_wr(CHA, 8'h28);
        rreg(CHA, 3, q); check("R5 clear tx re-raises rx", q, 8'h20);
        rreg(CHA, 2, q); check("R5 vector back to rx", q, 8'h0C);
        check("R3 irq rx pending", {7'b0, irq}, 8'h01);
        data_rd(CHA, q); check("R6 data value", q, 8'h33);
        check("R3 irq idle", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_read_promotes();
        logic [7:0] q;
        rx_pulse(CHA, 8'h44);
        data_wr(CHA, 8'h01);
        data_rd(CHA, q);
        rreg(CHA, 3, q); check("R6 read promotes tx", q, 8'h10);
        check("R3 irq tx pending", {7'b0, irq}, 8'h01);
        ctrl_wr(CHA, 8'h38);
        rreg(CHA, 3, q); check("R5 reset ius clears tx ius", q, 8'h00);
        check("R3 tx still pending", {7'b0, irq}, 8'h01);
        ctrl_wr(CHA, 8'h28);
        check("R5 clear tx drops irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tx_b();
        logic [7:0] q;
        wreg(CHB, 1, 8'h02);
        data_wr(CHB, 8'h99);
        rreg(CHA, 2, q); check("R7 B tx vector", q, 8'h00);
        rreg(CHA, 3, q); check("R8 B tx bit", q, 8'h02);
        rreg(CHB, 3, q); check("R8 B reg3 zero", q, 8'h00);
        rreg(CHB, 0, q); check("R9 tx empty", q, 8'h44);
        rreg(CHB, 1, q); check("R9 all sent", q, 8'h07);
        check("R9 tx irq", {7'b0, irq}, 8'h01);
        ctrl_wr(CHB, 8'h28);
        check("R5 B clear tx", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_rx_gate();
        logic [7:0] q;
        wreg(CHA, 3, 8'h00);
        rx_pulse(CHA, 8'h55);
        rreg(CHA, 0, q); check("R10 disabled drop", q, 8'h44);
        check("R10 no irq", {7'b0, irq}, 8'h00);
        wreg(CHA, 3, 8'h01);
        rx_pulse(CHA, 8'h11);
        rx_pulse(CHA, 8'h22);
        rreg(CHA, 8, q); check("R1 pointer 8 rx buffer", q, 8'h11);
        ctrl_rd(CHA, q); check("R2 pointer back to 0", q, 8'h45);
        data_rd(CHA, q); check("R10 first char kept", q, 8'h11);
    endtask

    task automatic t_break();
        logic [7:0] q;
        brk_pulse(CHB);
        check("R3 break irq", {7'b0, irq}, 8'h01);
        rreg(CHB, 0, q); check("R3 break status", q, 8'hC4);
        wreg(CHB, 15, 8'h00);
        check("R3 break masked", {7'b0, irq}, 8'h00);
        wreg(CHB, 15, 8'h80);
        check("R3 break unmasked", {7'b0, irq}, 8'h01);
        wreg(CHB, 9, 8'h40);
        check("R11 B reset clears break", {7'b0, irq}, 8'h00);
        rreg(CHB, 0, q); check("R11 B status after reset", q, 8'h44);
    endtask

    task automatic t_resets();
        logic [7:0] q;
        wreg(CHA, 1, 8'h02);
        data_wr(CHA, 8'h01);
        wreg(CHB, 1, 8'h02);
        data_wr(CHB, 8'h02);
        rreg(CHA, 3, q); check("R8 both tx", q, 8'h12);
        wreg(CHA, 9, 8'h40);
        rreg(CHA, 3, q); check("R11 code 01 resets B only", q, 8'h10);
        check("R11 A still requests", {7'b0, irq}, 8'h01);
        wreg(CHB, 9, 8'h80);
        rreg(CHA, 3, q); check("R11 code 10 resets A", q, 8'h00);
        check("R11 irq after resets", {7'b0, irq}, 8'h00);
        wreg(CHA, 9, 8'h10);
        wreg(CHA, 9, 8'hC0);
        rreg(CHA, 2, q); check("R11 reset write keeps status-high", q, 8'h60);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_rx_basic();
        t_stat_hi();
        t_tx_blocked();
        t_read_promotes();
        t_tx_b();
        t_rx_gate();
        t_break();
        t_resets();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule